// File: doc/BRIEF.md
# Hot-plug event interrupt aggregator

This block gathers the hot-plug events of a row of slots and the controller's command-completion flag into one interrupt locator word, and from it drives either a level interrupt wire or a one-cycle request for a message-signalled interrupt. Each slot keeps a sticky event latch, which software clears by writing ones, and a mask byte that keeps chosen events from raising the interrupt. Events arrive as raw per-slot strobes or as device insertion and removal requests. The block turns those requests into latch bits according to the slot's retention latch and power state.

Software reaches the control word, the locator and the per-slot words through a word-addressed write port with byte enables and a registered read port. The locator is recomputed from the registers every cycle, so it reflects every write and every event. When message mode is on, a message is requested only when the interrupt level changes from the last level requested. The last requested level is tracked in both modes and is cleared by reset.

Top module: `hp_irq_agg`

## Requirements
- R1: After reset every slot latch reads 0, every slot mask reads 7'h7F, the control word reads 32'h0000_000F, and the locator, `intx` and `msi_req` are 0.
- R2: Slot s sits at word address 2+s. Its latch is in bits 4:0 (0 presence change, 1 isolated power fault, 2 attention button, 3 retention latch change, 4 connected power fault) and its mask is in bits 14:8. A latch bit is set by `evt_set[5*s+b]` and stays set until software writes 1 to it with byte enable 0. The mask is written as a whole with byte enable 1.
- R3: When a latch bit is cleared by software in the same cycle that a new event sets it, the bit ends up set. Clearing one bit leaves the other bits unchanged.
- R4: Locator bit s+1 is 1 exactly when (latch AND NOT mask[4:0]) of slot s is nonzero. Both `locator` and word address 1 show this, and `locator` follows a register change one cycle after it.
- R5: Locator bit 0 is 1 exactly when command-detected (control bit 16) is 1 and the command interrupt disable (control bit 2) is 0.
- R6: Control word (address 0): bits 3:0 (0 global interrupt disable, 1 error disable, 2 command interrupt disable, 3 arbiter error disable) are written with byte enable 0. Bit 16 is set by `cmd_done` and bit 17 by `arb_err`. Either bit is cleared by writing 1 with byte enable 2. All other bits read 0.
- R7: `intx` is 1 exactly when message mode is off, the global disable is 0 and the locator is nonzero.
- R8: In message mode `msi_req` pulses for one cycle each time the level (global disable clear and locator nonzero) differs from the last level requested. The last level is updated every cycle in both modes, so switching into message mode while the level is high sends no message.
- R9: An insertion with `mrl_open` set sets latch bits 0, 2 and 3. An insertion with `mrl_open` clear sets only bit 2.
- R10: A removal request on a slot that is disabled with its power indicator off (`slot_off`) sets latch bits 0 and 3. A removal request on any other slot sets only bit 2.
- R11: Writes to the locator address change nothing, and no byte lane changes unless its byte enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte enables |
| rd_addr | input | AW | Read word address |
| rd_data | output | 32 | Read data, registered one cycle after `rd_addr` |
| msi_en | input | 1 | Message-signalled interrupt mode enable |
| evt_set | input | 5*NUM_SLOTS | Raw event set strobes, five per slot |
| dev_insert | input | NUM_SLOTS | Device insertion request per slot |
| unplug_req | input | NUM_SLOTS | Device removal request per slot |
| mrl_open | input | NUM_SLOTS | Retention latch reads open, per slot |
| slot_off | input | NUM_SLOTS | Slot disabled with power indicator off, per slot |
| cmd_done | input | 1 | Controller command completed |
| arb_err | input | 1 | Arbiter error detected |
| locator | output | NUM_SLOTS+1 | Registered interrupt locator |
| intx | output | 1 | Level interrupt wire |
| msi_req | output | 1 | One-cycle message request |

## Verification
A stuck or lost latch bit shows at the ports two cycles after the event: in the locator and the interrupt outputs, and in the slot word one read later. The bench sweeps every latch and mask pattern on every slot, so a wrong bit position or a wrong mask polarity shows up as a locator mismatch. A stale last-level register shows as a missing or a doubled message one cycle after the level changes. The mode-switch and disable sequences expose it right away.

// File: rtl/hpi_pkg.sv
`timescale 1ns/1ps
package hpi_pkg;
  localparam int EVT_W  = 5;
  localparam int MASK_W = 7;

  // latch / mask bit positions (decoded by software)
  localparam int EV_PRES = 0;
  localparam int EV_IFLT = 1;
  localparam int EV_BTN  = 2;
  localparam int EV_MRL  = 3;
  localparam int EV_CFLT = 4;

  // control word bit positions
  localparam int CT_GDIS   = 0;
  localparam int CT_CMDDIS = 2;
  localparam int CT_CMDDET = 16;
  localparam int CT_ARBDET = 17;

  // word addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_LOC  = 1;
  localparam int SLOT_BASE = 2;
endpackage

// File: rtl/hpi_event_src.sv
`timescale 1ns/1ps
module hpi_event_src
  import hpi_pkg::*;
(
  input  logic [EVT_W-1:0] raw_set,
  input  logic             insert,
  input  logic             unplug,
  input  logic             mrl_open,
  input  logic             slot_off,
  output logic [EVT_W-1:0] set_bits
);
  always_comb begin
    set_bits = raw_set;
    if (insert) begin
      set_bits[EV_BTN] = 1'b1;
      if (mrl_open) begin
        set_bits[EV_MRL]  = 1'b1;
        set_bits[EV_PRES] = 1'b1;
      end
    end
    if (unplug) begin
      if (slot_off) begin
        set_bits[EV_MRL]  = 1'b1;
        set_bits[EV_PRES] = 1'b1;
      end else begin
        set_bits[EV_BTN] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hpi_slot_regs.sv
`timescale 1ns/1ps
module hpi_slot_regs
  import hpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              be_latch,
  input  logic              be_mask,
  input  logic [EVT_W-1:0]  clr_data,
  input  logic [MASK_W-1:0] mask_data,
  input  logic [EVT_W-1:0]  set_bits,
  output logic [EVT_W-1:0]  latch_q,
  output logic [MASK_W-1:0] mask_q,
  output logic              pending
);
  logic [EVT_W-1:0] clr;

  always_comb begin
    clr     = (wr_hit && be_latch) ? clr_data : '0;
    pending = |(latch_q & ~mask_q[EVT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      mask_q  <= '1;
    end else begin
      // a new event wins over a same-cycle clear
      latch_q <= (latch_q & ~clr) | set_bits;
      if (wr_hit && be_mask) mask_q <= mask_data;
    end
  end
endmodule

// File: rtl/hpi_ctrl_reg.sv
`timescale 1ns/1ps
module hpi_ctrl_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic       be_dis,
  input  logic       be_det,
  input  logic [3:0] dis_data,
  input  logic [1:0] det_clr,
  input  logic       cmd_done,
  input  logic       arb_err,
  output logic [3:0] dis_q,
  output logic       cmd_det,
  output logic       arb_det
);
  logic [1:0] clr;

  always_comb clr = (wr_hit && be_det) ? det_clr : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q   <= 4'hF;
      cmd_det <= 1'b0;
      arb_det <= 1'b0;
    end else begin
      if (wr_hit && be_dis) dis_q <= dis_data;
      cmd_det <= cmd_done | (cmd_det & ~clr[0]);
      arb_det <= arb_err  | (arb_det & ~clr[1]);
    end
  end
endmodule

// File: rtl/hpi_irq_out.sv
`timescale 1ns/1ps
module hpi_irq_out #(
  parameter int NSLOT = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NSLOT-1:0] slot_pend,
  input  logic           cmd_det,
  input  logic           cmd_dis,
  input  logic           gdis,
  input  logic           msi_en,
  output logic [NSLOT:0] loc_now,
  output logic [NSLOT:0] locator,
  output logic           intx,
  output logic           msi_req
);
  logic lvl;
  logic last_lvl;

  always_comb begin
    loc_now = {slot_pend, cmd_det & ~cmd_dis};
    lvl     = ~gdis & (|loc_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locator  <= '0;
      intx     <= 1'b0;
      msi_req  <= 1'b0;
      last_lvl <= 1'b0;
    end else begin
      locator  <= loc_now;
      intx     <= lvl & ~msi_en;
      msi_req  <= msi_en & (lvl != last_lvl);
      last_lvl <= lvl;
    end
  end
endmodule

// File: rtl/hp_irq_agg.sv
`timescale 1ns/1ps
module hp_irq_agg
  import hpi_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int AW = $clog2(NUM_SLOTS + SLOT_BASE)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [3:0]                 wr_be,
  input  logic [AW-1:0]              rd_addr,
  output logic [31:0]                rd_data,
  input  logic                       msi_en,
  input  logic [EVT_W*NUM_SLOTS-1:0] evt_set,
  input  logic [NUM_SLOTS-1:0]       dev_insert,
  input  logic [NUM_SLOTS-1:0]       unplug_req,
  input  logic [NUM_SLOTS-1:0]       mrl_open,
  input  logic [NUM_SLOTS-1:0]       slot_off,
  input  logic                       cmd_done,
  input  logic                       arb_err,
  output logic [NUM_SLOTS:0]         locator,
  output logic                       intx,
  output logic                       msi_req
);
  localparam int LOC_W = NUM_SLOTS + 1;

  logic [NUM_SLOTS-1:0][EVT_W-1:0]  latch_q;
  logic [NUM_SLOTS-1:0][MASK_W-1:0] mask_q;
  logic [NUM_SLOTS-1:0]             slot_pend;
  logic [3:0]                       dis_q;
  logic                             cmd_det, arb_det;
  logic [LOC_W-1:0]                 loc_now;
  logic [31:0]                      rd_mux;
  logic                             ctrl_hit;
  logic                             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[31:18], wr_data[15], wr_data[7:5], wr_be[3]};
  assign ctrl_hit = wr_en && (wr_addr == AW'(ADDR_CTRL));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [EVT_W-1:0] set_bits;
    logic             hit;

    assign hit = wr_en && (wr_addr == AW'(SLOT_BASE + s));

    hpi_event_src u_src (
      .raw_set (evt_set[EVT_W*s +: EVT_W]),
      .insert  (dev_insert[s]),
      .unplug  (unplug_req[s]),
      .mrl_open(mrl_open[s]),
      .slot_off(slot_off[s]),
      .set_bits(set_bits)
    );

    hpi_slot_regs u_regs (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (hit),
      .be_latch (wr_be[0]),
      .be_mask  (wr_be[1]),
      .clr_data (wr_data[EVT_W-1:0]),
      .mask_data(wr_data[8 +: MASK_W]),
      .set_bits (set_bits),
      .latch_q  (latch_q[s]),
      .mask_q   (mask_q[s]),
      .pending  (slot_pend[s])
    );
  end

  hpi_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (ctrl_hit),
    .be_dis  (wr_be[0]),
    .be_det  (wr_be[2]),
    .dis_data(wr_data[3:0]),
    .det_clr (wr_data[17:16]),
    .cmd_done(cmd_done),
    .arb_err (arb_err),
    .dis_q   (dis_q),
    .cmd_det (cmd_det),
    .arb_det (arb_det)
  );

  hpi_irq_out #(.NSLOT(NUM_SLOTS)) u_out (
    .clk      (clk),
    .rst      (rst),
    .slot_pend(slot_pend),
    .cmd_det  (cmd_det),
    .cmd_dis  (dis_q[CT_CMDDIS]),
    .gdis     (dis_q[CT_GDIS]),
    .msi_en   (msi_en),
    .loc_now  (loc_now),
    .locator  (locator),
    .intx     (intx),
    .msi_req  (msi_req)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_addr == AW'(ADDR_CTRL)) begin
      rd_mux[3:0]       = dis_q;
      rd_mux[CT_CMDDET] = cmd_det;
      rd_mux[CT_ARBDET] = arb_det;
    end else if (rd_addr == AW'(ADDR_LOC)) begin
      rd_mux = 32'(loc_now);
    end
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_addr == AW'(SLOT_BASE + i)) begin
        rd_mux = {17'b0, mask_q[i], 3'b0, latch_q[i]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/hp_irq_agg_chk.sv
`timescale 1ns/1ps
module hp_irq_agg_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               msi_en,
  input logic [NUM_SLOTS:0] locator,
  input logic               intx,
  input logic               msi_req
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (locator == '0 && !intx && !msi_req));

  a_r7_intx_has_source: assert property (@(posedge clk) disable iff (rst)
    intx |-> (locator != '0));

  a_r7_wire_quiet_in_msg_mode: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> !intx);

  a_r8_msg_needs_enable: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> $past(msi_en));
endmodule

bind hp_irq_agg hp_irq_agg_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .msi_en (msi_en),
  .locator(locator),
  .intx   (intx),
  .msi_req(msi_req)
);

// File: tb/hp_irq_agg_test.sv
`timescale 1ns/1ps
module hp_irq_agg_test;
  localparam int NS = 4;
  localparam int AW = $clog2(NS + 2);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          msi_en = 1'b0;
  logic [5*NS-1:0] evt_set = '0;
  logic [NS-1:0] dev_insert = '0, unplug_req = '0, mrl_open = '0, slot_off = '0;
  logic          cmd_done = 1'b0, arb_err = 1'b0;
  logic [NS:0]   locator;
  logic          intx, msi_req;

  int n_chk = 0;
  int n_fail = 0;

  hp_irq_agg #(.NUM_SLOTS(NS)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_addr(rd_addr), .rd_data(rd_data), .msi_en(msi_en),
    .evt_set(evt_set), .dev_insert(dev_insert), .unplug_req(unplug_req),
    .mrl_open(mrl_open), .slot_off(slot_off), .cmd_done(cmd_done),
    .arb_err(arb_err), .locator(locator), .intx(intx), .msi_req(msi_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_be = be;
    step();
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = AW'(a);
    step();
    d = rd_data;
  endtask

  function automatic logic [31:0] sw(input logic [6:0] m, input logic [4:0] l);
    return {17'b0, m, 3'b0, l};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) step();
    rst = 1'b0;
    step();

    // R1 reset state
    chk("R1 locator", 32'(locator), 0);
    chk("R1 intx", 32'(intx), 0);
    chk("R1 msi_req", 32'(msi_req), 0);
    rd(0, d); chk("R1 ctrl", d, 32'h0000_000F);
    for (int s = 0; s < NS; s++) begin
      rd(2 + s, d); chk("R1 slot word", d, 32'h0000_7F00);
    end

    // R2/R4 sweep: every latch and mask pattern on every slot
    for (int s = 0; s < NS; s++) begin
      for (int m = 0; m < 32; m++) begin
        for (int l = 0; l < 32; l++) begin
          wr(2 + s, sw({2'b11, 5'(m)}, 5'h1F), 4'b0011);
          evt_set[5*s +: 5] = 5'(l);
          step();
          evt_set = '0;
          rd(2 + s, d);
          chk("R2 latch sticky / mask", d, sw({2'b11, 5'(m)}, 5'(l)));
          chk("R4 locator slot bit", 32'(locator),
              ((l & ~m & 31) != 0) ? (32'd1 << (s + 1)) : 32'd0);
        end
      end
      wr(2 + s, sw(7'h7F, 5'h1F), 4'b0011);
    end

    // R6/R11 control word
    wr(0, 32'h0000_0005, 4'b0010); rd(0, d); chk("R11 byte enable gate", d, 32'h0000_000F);
    wr(0, 32'h0000_000A, 4'b0001); rd(0, d); chk("R6 disable bits", d, 32'h0000_000A);
    cmd_done = 1'b1; step(); cmd_done = 1'b0;
    rd(0, d); chk("R6 cmd detected", d, 32'h0001_000A);
    chk("R5 locator cmd bit", 32'(locator), 1);
    chk("R7 intx level", 32'(intx), 1);
    arb_err = 1'b1; step(); arb_err = 1'b0;
    rd(0, d); chk("R6 arb detected", d, 32'h0003_000A);
    wr(0, 32'h0002_0000, 4'b0100); rd(0, d); chk("R6 arb w1c", d, 32'h0001_000A);
    wr(0, 32'h0000_000E, 4'b0001); step();
    chk("R5 cmd int disabled", 32'(locator), 0);
    chk("R7 intx idle", 32'(intx), 0);
    wr(0, 32'h0000_000A, 4'b0001); step();
    chk("R5 cmd int re-enabled", 32'(locator), 1);
    rd(1, d); chk("R4 locator word", d, 32'h1);
    wr(0, 32'h0001_0000, 4'b0100); step();
    chk("R5 cmd w1c", 32'(locator), 0);
    wr(1, 32'hFFFF_FFFF, 4'hF);
    rd(0, d); chk("R11 locator write ctrl", d, 32'h0000_000A);
    rd(2, d); chk("R11 locator write slot", d, 32'h0000_7F00);
    rd(1, d); chk("R11 locator write loc", d, 32'h0);

    // R3 set beats clear
    wr(2, sw(7'h60, 5'h0), 4'b0010);
    evt_set[0] = 1'b1;
    wr(2, 32'h1, 4'b0001);
    evt_set = '0;
    rd(2, d); chk("R3 set wins", d, sw(7'h60, 5'h01));
    wr(2, 32'h1, 4'b0001); rd(2, d); chk("R3 clear", d, sw(7'h60, 5'h00));
    evt_set[4:0] = 5'h1F; step(); evt_set = '0;
    wr(2, 32'h05, 4'b0001); rd(2, d); chk("R3 partial clear", d, sw(7'h60, 5'h1A));
    wr(2, 32'h1F, 4'b0001);

    // R9 insertion
    wr(3, sw(7'h60, 5'h0), 4'b0010);
    dev_insert[1] = 1'b1; mrl_open[1] = 1'b1; step(); dev_insert = '0; mrl_open = '0;
    rd(3, d); chk("R9 insert latch open", d, sw(7'h60, 5'h0D));
    chk("R9 locator", 32'(locator), 32'h4);
    wr(3, 32'h1F, 4'b0001);
    dev_insert[1] = 1'b1; step(); dev_insert = '0;
    rd(3, d); chk("R9 insert latch closed", d, sw(7'h60, 5'h04));
    wr(3, 32'h1F, 4'b0001);

    // R10 removal
    unplug_req[1] = 1'b1; slot_off[1] = 1'b1; step(); unplug_req = '0; slot_off = '0;
    rd(3, d); chk("R10 removal off slot", d, sw(7'h60, 5'h09));
    wr(3, 32'h1F, 4'b0001);
    unplug_req[1] = 1'b1; step(); unplug_req = '0;
    rd(3, d); chk("R10 removal live slot", d, sw(7'h60, 5'h04));
    wr(3, 32'h1F, 4'b0001);

    // R8 message mode
    msi_en = 1'b1; step(); step();
    chk("R8 idle", 32'(msi_req), 0);
    wr(4, sw(7'h60, 5'h0), 4'b0010);
    evt_set[11] = 1'b1; step(); evt_set = '0; step();
    chk("R8 rise message", 32'(msi_req), 1);
    chk("R7 wire quiet in msg mode", 32'(intx), 0);
    step(); chk("R8 one cycle", 32'(msi_req), 0);
    step(); chk("R8 held level", 32'(msi_req), 0);
    wr(4, 32'h02, 4'b0001); step();
    chk("R8 fall message", 32'(msi_req), 1);
    step(); chk("R8 fall one cycle", 32'(msi_req), 0);
    msi_en = 1'b0;
    evt_set[11] = 1'b1; step(); evt_set = '0; step();
    chk("R7 level mode intx", 32'(intx), 1);
    chk("R8 no message in level mode", 32'(msi_req), 0);
    msi_en = 1'b1; step();
    chk("R8 mode switch no message", 32'(msi_req), 0);
    chk("R7 intx off in msg mode", 32'(intx), 0);
    wr(0, 32'h0000_000B, 4'b0001); step();
    chk("R8 global disable message", 32'(msi_req), 1);
    step(); chk("R8 disable one cycle", 32'(msi_req), 0);

    // R1 reset with state present
    rst = 1'b1; step(); step(); rst = 1'b0; step();
    rd(4, d); chk("R1 reset clears latch", d, 32'h0000_7F00);
    rd(0, d); chk("R1 reset ctrl", d, 32'h0000_000F);
    chk("R1 reset locator", 32'(locator), 0);

    summary();
    $finish;
  end
endmodule